// File: doc/BRIEF.md
# Nonvolatile SRAM Host Sequencer

This block sits between a synchronous command source and an asynchronous static RAM that carries a nonvolatile shadow array. A command arrives on a valid/ready handshake. The block then drives the memory's address, its write-data bus and four active-low control strobes: chip enable, write enable, output enable and nonvolatile enable. It paces every phase of the access in whole clock cycles. Read data comes back on a single-cycle response strobe.

A store command copies the whole SRAM into the nonvolatile array. The block sequences the store launch in the required order. It then stays busy for the full self-timed store interval before it takes another command.

Every timing interval is set as a parameter in nanoseconds, along with the clock period. Each interval is converted to a cycle count by rounding up, with a floor of one cycle. The same netlist can therefore serve any speed grade at any clock rate.

Top module: `nvsram_seq`

## Requirements
- R1: While reset is asserted and right after it, cmd_ready_o is 1, all four strobes are high, mem_dq_oe_o is 0 and rsp_valid_o is 0.
- R2: An accepted command with cmd_op_i = 2'b00 (read) holds mem_e_no and mem_g_no low, with mem_w_no and mem_ne_no high, for exactly the read cycle count. The data on mem_dq_i is captured at the clock edge that ends this window and returned on rsp_rdata_o while rsp_valid_o is high for one cycle. Every read yields exactly one response, and responses come back in order.
- R3: mem_addr_o changes only at a clock edge where mem_e_no and mem_w_no were both high just before that edge.
- R4: An accepted command with cmd_op_i = 2'b01 (write) holds mem_e_no and mem_w_no low for max(write pulse, data setup) cycles. During that time mem_dq_o carries the command's data and does not change, and the written byte must be readable afterwards.
- R5: mem_dq_oe_o is high only while mem_w_no is low and in the single hold cycle after mem_w_no rises. mem_g_no is high whenever mem_dq_oe_o is high.
- R6: Whenever mem_g_no is low, mem_ne_no and mem_w_no are high. Ordinary reads and writes never pull mem_ne_no low.
- R7: An accepted command with cmd_op_i = 2'b10 (store) first pulls mem_ne_no and mem_e_no low for one cycle with mem_w_no and mem_g_no high. It then holds mem_w_no and mem_ne_no low together for the store-launch cycle count, keeps mem_g_no high throughout, and raises mem_w_no and mem_ne_no on the same edge.
- R8: After the store launch ends, cmd_ready_o stays low with all strobes high for exactly the store-time cycle count.
- R9: cmd_ready_o is low from the edge after acceptance until the sequence ends. A command presented while cmd_ready_o is low is not accepted and has no effect on memory.
- R10: Cycle counts are ceil(t_ns / CLK_NS) with a floor of 1. A 25 ns read at a 10 ns clock therefore takes 3 cycles.
- R11: cmd_op_i = 2'b11 is accepted and dropped. No strobe goes low, and cmd_ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op_i | input | 2 | 00 read, 01 write, 10 store, 11 dropped |
| cmd_addr_i | input | AW | Command address |
| cmd_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | DW | Read data |
| mem_addr_o | output | AW | Memory address |
| mem_dq_o | output | DW | Memory write data |
| mem_dq_oe_o | output | 1 | Write-data driver enable |
| mem_dq_i | input | DW | Memory read data |
| mem_e_no | output | 1 | Chip enable, active low |
| mem_w_no | output | 1 | Write enable, active low |
| mem_g_no | output | 1 | Output enable, active low |
| mem_ne_no | output | 1 | Nonvolatile enable, active low |

## Verification
The memory model in the bench drives a poison byte until the read window has lasted the full access count. A design that samples one cycle early therefore returns the wrong data rather than a lucky match. The bench checks the exact lengths of the write and store pulses, and it tracks the order of mem_ne_no and mem_w_no. A shortened pulse, or a write enable that falls before the nonvolatile enable, is reported at the strobe level. It also catches a store wait that is too short, a command that is taken while the block is busy, and a reserved opcode that toggles a strobe. Each of these shows up as a wrong busy count or as corrupted read-back data at the boundary addresses.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_STORE = 2'b10,
    OP_NOP   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_WR_HOLD,
    S_ST_NE,
    S_ST_INIT,
    S_ST_WAIT
  } state_e;

  typedef struct packed {
    logic e_n;
    logic w_n;
    logic g_n;
    logic ne_n;
    logic dq_oe;
  } strobe_t;

  // round up to whole cycles, never zero
  function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t decode(state_e s);
    strobe_t r;
    r = '{e_n: 1'b1, w_n: 1'b1, g_n: 1'b1, ne_n: 1'b1, dq_oe: 1'b0};
    case (s)
      S_RD:      begin r.e_n = 1'b0; r.g_n = 1'b0; end
      S_WR:      begin r.e_n = 1'b0; r.w_n = 1'b0; r.dq_oe = 1'b1; end
      S_WR_HOLD: r.dq_oe = 1'b1;
      S_ST_NE:   begin r.e_n = 1'b0; r.ne_n = 1'b0; end
      S_ST_INIT: begin r.e_n = 1'b0; r.w_n = 1'b0; r.ne_n = 1'b0; end
      default:   ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nvsram_timer.sv
module nvsram_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R10: a loaded count never leaves done high on the next cycle unless it was zero
  timer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !done_o);

endmodule

// File: rtl/nvsram_fsm.sv
module nvsram_fsm
  import nvsram_pkg::*;
#(
  parameter int unsigned AA_C    = 3,
  parameter int unsigned WRP_C   = 2,
  parameter int unsigned SINIT_C = 2,
  parameter int unsigned ST_C    = 1000,
  parameter int unsigned TW      = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] op_i,
  output logic       ready_o,
  output logic       accept_o,
  output logic       rd_done_o,
  output strobe_t    strb_o
);

  state_e        state_q, state_d;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  strobe_t       strb_q;

  assign ready_o  = (state_q == S_IDLE);
  assign accept_o = valid_i && ready_o;

  always_comb begin
    state_d   = state_q;
    rd_done_o = 1'b0;
    case (state_q)
      S_IDLE: if (valid_i) begin
        case (op_e'(op_i))
          OP_READ:  state_d = S_RD;
          OP_WRITE: state_d = S_WR;
          OP_STORE: state_d = S_ST_NE;
          default:  state_d = S_IDLE;
        endcase
      end
      S_RD:      if (t_done) begin state_d = S_IDLE; rd_done_o = 1'b1; end
      S_WR:      if (t_done) state_d = S_WR_HOLD;
      S_WR_HOLD: if (t_done) state_d = S_IDLE;
      S_ST_NE:   if (t_done) state_d = S_ST_INIT;
      S_ST_INIT: if (t_done) state_d = S_ST_WAIT;
      S_ST_WAIT: if (t_done) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  assign t_load = (state_d != state_q);

  always_comb begin
    case (state_d)
      S_RD:      t_val = TW'(AA_C - 1);
      S_WR:      t_val = TW'(WRP_C - 1);
      S_ST_INIT: t_val = TW'(SINIT_C - 1);
      S_ST_WAIT: t_val = TW'(ST_C - 1);
      default:   t_val = '0;
    endcase
  end

  nvsram_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      strb_q  <= decode(S_IDLE);
    end else begin
      state_q <= state_d;
      strb_q  <= decode(state_d);
    end
  end

  assign strb_o = strb_q;

  // R9
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && op_i != 2'b11 |=> !ready_o);

endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter int unsigned DW          = 8,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned T_AA_NS     = 25,
  parameter int unsigned T_WP_NS     = 20,
  parameter int unsigned T_DW_NS     = 10,
  parameter int unsigned T_SINIT_NS  = 20,
  parameter int unsigned T_STORE_NS  = 10000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_e_no,
  output logic          mem_w_no,
  output logic          mem_g_no,
  output logic          mem_ne_no
);

  localparam int unsigned AA_C    = ns2cyc(T_AA_NS, CLK_NS);
  localparam int unsigned WRP_C   = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
  localparam int unsigned SINIT_C = ns2cyc(T_SINIT_NS, CLK_NS);
  localparam int unsigned ST_C    = ns2cyc(T_STORE_NS, CLK_NS);
  localparam int unsigned MAX_C   = umax(umax(AA_C, WRP_C), umax(SINIT_C, ST_C));
  localparam int unsigned TW      = $clog2(MAX_C + 1);

  logic          accept, rd_done;
  strobe_t       strb;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;

  nvsram_fsm #(
    .AA_C(AA_C), .WRP_C(WRP_C), .SINIT_C(SINIT_C), .ST_C(ST_C), .TW(TW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .ready_o   (cmd_ready_o),
    .accept_o  (accept),
    .rd_done_o (rd_done),
    .strb_o    (strb)
  );

  // command latch: only loads while idle, so strobes are high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= rd_done;
      if (rd_done) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = strb.dq_oe;
  assign mem_e_no    = strb.e_n;
  assign mem_w_no    = strb.w_n;
  assign mem_g_no    = strb.g_n;
  assign mem_ne_no   = strb.ne_n;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  // R2
  rsp_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_g_no) && $past(!mem_e_no));

  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> $past(mem_e_no) && $past(mem_w_no));

  // R4
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_w_no && $past(!mem_w_no)) |-> $stable(mem_dq_o));

  // R5
  drive_g_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_g_no && (!mem_w_no || $past(!mem_w_no)));

  // R6
  read_ne_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_g_no |-> mem_ne_no && mem_w_no);

  // R7
  ne_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_w_no) && !mem_ne_no) |-> $past(!mem_ne_no) && mem_g_no);

  // R8
  store_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_w_no) && $past(!mem_ne_no)) |-> !cmd_ready_o && mem_ne_no);

endmodule

// File: tb/tb_nvsram_seq.sv
module tb_nvsram_seq;

  localparam int AW = 11;
  localparam int DW = 8;
  // expected counts worked out by hand at a 10 ns clock
  localparam int AA_C    = 3;    // 25 ns -> 3
  localparam int WRP_C   = 2;    // max(20 ns, 10 ns) -> 2
  localparam int SINIT_C = 2;    // 20 ns -> 2
  localparam int ST_C    = 200;  // 2000 ns -> 200
  localparam logic [DW-1:0] POISON = 8'hEE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq, mem_dq_in;
  logic          mem_oe, e_n, w_n, g_n, ne_n;

  always #5 clk = ~clk;

  nvsram_seq #(.CLK_NS(10), .T_STORE_NS(2000)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq), .mem_dq_oe_o(mem_oe),
    .mem_dq_i(mem_dq_in),
    .mem_e_no(e_n), .mem_w_no(w_n), .mem_g_no(g_n), .mem_ne_no(ne_n)
  );

  int total = 0;
  int bad = 0;
  bit reported = 0;

  logic [DW-1:0] sram [1<<AW];
  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_q [$];
  int aa_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // device model: output valid only after the full access window
  always @(posedge clk) begin
    if (e_n || g_n) aa_cnt <= 0;
    else aa_cnt <= aa_cnt + 1;
  end
  assign mem_dq_in = (!e_n && !g_n && w_n && aa_cnt >= AA_C - 1) ? sram[mem_addr] : POISON;

  // monitor
  int  rd_run = 0, wr_run = 0, st_run = 0, wait_cnt = 0;
  bit  waiting = 0;
  logic p_e = 1, p_w = 1, p_ne = 1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected response", int'(rsp_rdata), 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R2 read data", int'(rsp_rdata), int'(e));
        end
      end
      if (!e_n && !g_n) rd_run++;
      else if (rd_run != 0) begin
        check(rd_run == AA_C, "R10 read window cycles", rd_run, AA_C);
        rd_run = 0;
      end
      if (!g_n) check(ne_n && w_n, "R6 ne/w high while reading", {ne_n, w_n}, 3);
      if ((!e_n || !w_n) && (!p_e || !p_w))
        check(mem_addr == p_addr, "R3 address moved while selected", int'(mem_addr), int'(p_addr));
      if (mem_oe) check((!w_n || !p_w) && g_n, "R5 driver window", {w_n, p_w, g_n}, 0);
      // write pulse
      if (!w_n && ne_n) begin
        wr_run++;
        check(mem_oe, "R4 data driven in pulse", int'(mem_oe), 1);
        if (wr_run > 1) check(mem_dq == p_dq, "R4 data stable", int'(mem_dq), int'(p_dq));
      end else if (wr_run != 0) begin
        check(wr_run == WRP_C, "R4 write pulse cycles", wr_run, WRP_C);
        if (!p_e) sram[p_addr] = p_dq;
        wr_run = 0;
      end
      // store launch
      if (!w_n && !ne_n) begin
        if (st_run == 0) check(!p_ne && p_w, "R7 ne falls before w", {p_ne, p_w}, 1);
        st_run++;
        check(g_n && !e_n, "R7 g high e low in launch", {g_n, e_n}, 2);
      end else if (st_run != 0) begin
        check(st_run == SINIT_C, "R7 launch cycles", st_run, SINIT_C);
        check(ne_n && w_n, "R7 w and ne rise together", {ne_n, w_n}, 3);
        st_run = 0;
        waiting = 1;
        wait_cnt = 0;
      end
      if (waiting) begin
        if (!cmd_ready) begin
          wait_cnt++;
          if (!(e_n && w_n && g_n && ne_n))
            check(0, "R8 strobes high in wait", {e_n, w_n, g_n, ne_n}, 15);
        end else begin
          check(wait_cnt == ST_C, "R8 store wait cycles", wait_cnt, ST_C);
          waiting = 0;
        end
      end
    end
    p_e = e_n; p_w = w_n; p_ne = ne_n; p_addr = mem_addr; p_dq = mem_dq;
  end

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ref_mem[a] = d;
    send(2'b01, a, d);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    exp_q.push_back(ref_mem[a]);
    send(2'b00, a, '0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin sram[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cmd_ready && e_n && w_n && g_n && ne_n && !mem_oe && !rsp_valid,
          "R1 reset state", {cmd_ready, e_n, w_n, g_n, ne_n, mem_oe, rsp_valid}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && e_n && w_n && g_n && ne_n && !mem_oe && !rsp_valid,
          "R1 after reset", {cmd_ready, e_n, w_n, g_n, ne_n, mem_oe, rsp_valid}, 7'b1111100);

    // R4 / R2 patterns, boundary addresses
    do_write(11'h005, 8'hA5);
    do_write(11'h000, 8'h3C);
    do_write(11'h7FF, 8'hC3);
    do_write(11'h2AA, 8'h55);
    do_write(11'h555, 8'hAA);
    do_read(11'h005);
    do_read(11'h000);
    do_read(11'h7FF);
    do_read(11'h2AA);
    do_read(11'h555);
    do_read(11'h123);
    // write then read back to back, overwrite
    do_write(11'h555, 8'h0F);
    do_read(11'h555);
    do_write(11'h000, 8'hFF);
    do_read(11'h000);

    // R11 reserved opcode dropped
    send(2'b11, 11'h005, 8'h00);
    for (int i = 0; i < 5; i++) begin
      check(cmd_ready && e_n && w_n && g_n && ne_n && !mem_oe, "R11 reserved op inert",
            {cmd_ready, e_n, w_n, g_n, ne_n, mem_oe}, 6'b111110);
      @(negedge clk);
    end
    do_read(11'h005);

    // R7 / R8 store, then R9 busy command ignored
    send(2'b10, 11'h000, 8'h00);
    repeat (5) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 11'h005; cmd_wdata = 8'h00;
    for (int i = 0; i < 30; i++) begin
      check(!cmd_ready, "R9 ready low while busy", int'(cmd_ready), 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_idle();
    do_read(11'h005);   // R9 still A5
    do_read(11'h7FF);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses returned", exp_q.size(), 0);
    check(!waiting, "R8 wait finished", int'(waiting), 0);
    report();
  end

endmodule